// File: doc/BRIEF.md
# Tagged Result Broadcast Arbiter

This block sits between the producers of an out-of-order floating-point core and the single shared result bus. Load buffers, adder stations and multiplier stations each raise a completion request with the 64-bit result they hold. Every cycle the block picks at most one of them and drives that result onto the bus, together with a 4-bit tag that names the producer. Every consumer watches that bus at the same moment.

The grant is returned to the winner in the same cycle its value is on the bus, so the station can free itself on that clock edge. A producer that loses keeps its request and its data steady and competes again in the next cycle. The choice rotates round-robin over all producers. A long stream of quick completions therefore cannot lock out a slow one, such as a finished divide.

The grant and the bus outputs are combinational from the requests. The only state is the pointer to the last winner, which the clock updates.

Top module: `result_bus_arbiter`

## Requirements
- R1: In any cycle at most one grant line is high across all producers, and a grant goes only to a producer whose request is high in that cycle.
- R2: `bus_valid` is high exactly in the cycles where at least one request is high. While it is low, `bus_tag` and `bus_data` are zero.
- R3: Tags are fixed by position. Load buffer i carries tag i+1 (1 to 6), adder station j carries tag 7+j (7 to 9) and multiplier station k carries tag 10+k (10 to 11). Tag 0 is never driven while `bus_valid` is high.
- R4: `bus_data` equals the data word of the granted producer in the same cycle.
- R5: The winner's grant line is high in the same cycle that its tag and data are on the bus.
- R6: Producers are ordered by their tag. After reset the search starts at tag 1. After tag t wins, the next search starts at the tag that follows t, and wraps from 11 back to 1.
- R7: A producer whose request stays high is granted within 11 cycles, however many other requests are pending.
- R8: Reset, synchronous and active high, puts the rotation back to its starting point, so the next search starts at tag 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 6 | Completion requests from the load buffers |
| ld_data | input | 384 | Results of the load buffers, 64 bits each, buffer 0 in the low bits |
| add_req | input | 3 | Completion requests from the adder stations |
| add_data | input | 192 | Results of the adder stations, 64 bits each |
| mul_req | input | 2 | Completion requests from the multiplier stations |
| mul_data | input | 128 | Results of the multiplier stations, 64 bits each |
| ld_gnt | output | 6 | Grants to the load buffers |
| add_gnt | output | 3 | Grants to the adder stations |
| mul_gnt | output | 2 | Grants to the multiplier stations |
| bus_valid | output | 1 | Result bus carries a value |
| bus_tag | output | 4 | Tag of the producer on the bus |
| bus_data | output | 64 | Value on the bus |

## Verification
The bench first drives a lone request from each producer in turn. This shows that every position maps to its own tag and data word, separately from any arbitration. Then all eleven requests go up at once, and the grant order must follow the rotation exactly from tag 1 to tag 11. Next, the loads request again each time they are granted while one multiplier waits. This separates true round-robin from a fixed priority, which would starve the multiplier. A reset in the middle of a run, followed by a full set of requests, shows that the rotation restarts at tag 1.

// File: rtl/rbus_pkg.sv
package rbus_pkg;

    localparam int TAG_W  = 4;
    localparam int DATA_W = 64;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } bus_beat_t;

    // producer position p (loads, then adders, then multipliers) -> tag p+1
    function automatic logic [TAG_W-1:0] tag_of(input int unsigned pos);
        return TAG_W'(pos + 1);
    endfunction

endpackage

// File: rtl/rr_grant.sv
module rr_grant #(
    parameter int NREQ  = 11,
    localparam int IDX_W = $clog2(NREQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREQ-1:0]  req,
    output logic [NREQ-1:0]  gnt,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             any
);

    logic [IDX_W-1:0] last_q;

    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int k = 1; k <= NREQ; k++) begin
            int idx;
            idx = (int'(last_q) + k) % NREQ;
            if (!any && req[idx]) begin
                any          = 1'b1;
                gnt_idx      = IDX_W'(idx);
                gnt[idx]     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= IDX_W'(NREQ - 1);
        else if (any)
            last_q <= gnt_idx;
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)) else $error("more than one grant"); // R1

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0) else $error("grant without request"); // R1

    // wait counters per producer bound the time a held request can lose
    for (genvar g = 0; g < NREQ; g++) begin : g_wait
        logic [IDX_W:0] wait_q;
        always_ff @(posedge clk) begin
            if (rst || !req[g] || gnt[g])
                wait_q <= '0;
            else
                wait_q <= wait_q + 1'b1;
        end
        AST_NO_STARVE: assert property (@(posedge clk) disable iff (rst)
            int'(wait_q) < NREQ) else $error("request starved"); // R7
    end

endmodule

// File: rtl/result_select.sv
module result_select
    import rbus_pkg::*;
#(
    parameter int NREQ  = 11,
    localparam int IDX_W = $clog2(NREQ)
) (
    input  logic [NREQ*DATA_W-1:0] data_all,
    input  logic [IDX_W-1:0]       gnt_idx,
    input  logic                   any,
    output bus_beat_t              beat
);

    always_comb begin
        beat.valid = any;
        beat.tag   = '0;
        beat.data  = '0;
        if (any) begin
            beat.tag  = tag_of(int'(gnt_idx));
            beat.data = data_all[int'(gnt_idx)*DATA_W +: DATA_W];
        end
    end

endmodule

// File: rtl/result_bus_arbiter.sv
module result_bus_arbiter
    import rbus_pkg::*;
#(
    parameter int N_LD  = 6,
    parameter int N_ADD = 3,
    parameter int N_MUL = 2,
    localparam int NREQ  = N_LD + N_ADD + N_MUL,
    localparam int IDX_W = $clog2(NREQ)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_LD-1:0]         ld_req,
    input  logic [N_LD*DATA_W-1:0]  ld_data,
    input  logic [N_ADD-1:0]        add_req,
    input  logic [N_ADD*DATA_W-1:0] add_data,
    input  logic [N_MUL-1:0]        mul_req,
    input  logic [N_MUL*DATA_W-1:0] mul_data,
    output logic [N_LD-1:0]         ld_gnt,
    output logic [N_ADD-1:0]        add_gnt,
    output logic [N_MUL-1:0]        mul_gnt,
    output logic                    bus_valid,
    output logic [TAG_W-1:0]        bus_tag,
    output logic [DATA_W-1:0]       bus_data
);

    logic [NREQ-1:0]        req_all;
    logic [NREQ-1:0]        gnt_all;
    logic [NREQ*DATA_W-1:0] data_all;
    logic [IDX_W-1:0]       gnt_idx;
    logic                   any;
    bus_beat_t              beat;

    assign req_all  = {mul_req, add_req, ld_req};
    assign data_all = {mul_data, add_data, ld_data};

    rr_grant #(.NREQ(NREQ)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .req     (req_all),
        .gnt     (gnt_all),
        .gnt_idx (gnt_idx),
        .any     (any)
    );

    result_select #(.NREQ(NREQ)) u_sel (
        .data_all (data_all),
        .gnt_idx  (gnt_idx),
        .any      (any),
        .beat     (beat)
    );

    assign ld_gnt    = gnt_all[N_LD-1:0];
    assign add_gnt   = gnt_all[N_LD +: N_ADD];
    assign mul_gnt   = gnt_all[N_LD+N_ADD +: N_MUL];
    assign bus_valid = beat.valid;
    assign bus_tag   = beat.tag;
    assign bus_data  = beat.data;

    AST_VALID_IFF_REQ: assert property (@(posedge clk) disable iff (rst)
        bus_valid == (req_all != '0)) else $error("valid mismatch"); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |-> (bus_tag == '0 && bus_data == '0)) else $error("idle bus not zero"); // R2

    AST_TAG_NONZERO: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> bus_tag != '0) else $error("zero tag broadcast"); // R3

    AST_GRANT_WITH_BEAT: assert property (@(posedge clk) disable iff (rst)
        bus_valid == (gnt_all != '0)) else $error("grant and beat apart"); // R5

endmodule

// File: tb/result_bus_arbiter_test.sv
module result_bus_arbiter_test;

    localparam int NP = 11;

    typedef struct {
        logic          valid;
        logic [3:0]    tag;
        logic [63:0]   data;
        logic [NP-1:0] gnt;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    ld_req  = '0;
    logic [383:0]  ld_data = '0;
    logic [2:0]    add_req = '0;
    logic [191:0]  add_data = '0;
    logic [1:0]    mul_req = '0;
    logic [127:0]  mul_data = '0;
    logic [5:0]    ld_gnt;
    logic [2:0]    add_gnt;
    logic [1:0]    mul_gnt;
    logic          bus_valid;
    logic [3:0]    bus_tag;
    logic [63:0]   bus_data;

    int tests = 0;
    int fails = 0;
    exp_t q[$];
    logic [NP-1:0] req_m = '0;
    logic [63:0]   dm [NP];
    int last_m = NP - 1;
    int seq = 0;
    bit mul1_seen = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    result_bus_arbiter uut (
        .clk(clk), .rst(rst),
        .ld_req(ld_req), .ld_data(ld_data),
        .add_req(add_req), .add_data(add_data),
        .mul_req(mul_req), .mul_data(mul_data),
        .ld_gnt(ld_gnt), .add_gnt(add_gnt), .mul_gnt(mul_gnt),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data)
    );

    // driver: load new requests, drive ports, push expectation, advance model
    task automatic step(input logic [NP-1:0] new_req);
        exp_t e;
        int win;
        for (int p = 0; p < NP; p++) begin
            if (new_req[p] && !req_m[p]) begin
                seq++;
                dm[p] = {32'(p + 1) ^ 32'hA5A5_0000, 32'(seq * 7919)};
            end
        end
        req_m = req_m | new_req;
        {mul_req, add_req, ld_req} = req_m;
        for (int p = 0; p < NP; p++) begin
            if (p < 6)      ld_data[p*64 +: 64]      = dm[p];
            else if (p < 9) add_data[(p-6)*64 +: 64] = dm[p];
            else            mul_data[(p-9)*64 +: 64] = dm[p];
        end
        win = -1;
        for (int k = 1; k <= NP; k++) begin
            int idx;
            idx = (last_m + k) % NP;
            if (win < 0 && req_m[idx]) win = idx;
        end
        e.valid = (win >= 0);
        e.tag   = (win >= 0) ? 4'(win + 1) : 4'd0;
        e.data  = (win >= 0) ? dm[win] : 64'd0;
        e.gnt   = '0;
        if (win >= 0) e.gnt[win] = 1'b1;
        q.push_back(e);
        @(posedge clk);
        #1;
        if (win >= 0) begin
            last_m = win;
            req_m[win] = 1'b0;
        end
    endtask

    // monitor: compare bus against scoreboard in the middle of each cycle
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            logic [NP-1:0] g;
            e = q.pop_front();
            g = {mul_gnt, add_gnt, ld_gnt};
            if (mul_gnt[1]) mul1_seen = 1'b1;
            tests++;
            if (bus_valid !== e.valid) begin
                fails++;
                $display("FAIL R2 valid got %0b exp %0b", bus_valid, e.valid);
            end
            tests++;
            if (bus_tag !== e.tag) begin
                fails++;
                $display("FAIL R3/R6 tag got %0d exp %0d", bus_tag, e.tag);
            end
            tests++;
            if (bus_data !== e.data) begin
                fails++;
                $display("FAIL R4 data got %h exp %h", bus_data, e.data);
            end
            tests++;
            if (g !== e.gnt || $countones(g) > 1) begin
                fails++;
                $display("FAIL R1/R5 gnt got %b exp %b", g, e.gnt);
            end
        end
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) dm[p] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // reset state, idle bus: R2
        step('0);
        step('0);
        // lone requests from each producer: R3 tag map, R4 data
        for (int p = 0; p < NP; p++) begin
            step(NP'(1) << p);
            step('0);
        end
        // all at once: R6 rotation through tags 1..11
        step('1);
        for (int k = 0; k < NP; k++) step('0);
        // R7: loads re-request constantly, multiplier 1 waits
        mul1_seen = 1'b0;
        step({1'b1, 4'b0, 6'h3F});
        for (int k = 0; k < NP - 1; k++) step(11'h03F);
        tests++;
        if (!mul1_seen) begin
            fails++;
            $display("FAIL R7 mul1 granted got 0 exp 1");
        end
        for (int k = 0; k < 12; k++) step('0);
        // R8: reset in the middle, rotation restarts at tag 1
        step(11'b000_0011_0000);
        #1 rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        req_m = '0;
        last_m = NP - 1;
        q.delete();
        step('1);
        for (int k = 0; k < NP + 1; k++) step('0);
        @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule